// File: doc/BRIEF.md
# Fixed-Frequency PWM Gate Generator with Leading-Edge Blanking

This block produces the switch gate pulse for a fixed-frequency power stage. A free-running counter forms a digital sawtooth whose length in clock cycles comes from a period input. The period value is clamped to a legal range. At every period boundary the block samples a new period and a new on-time request. The gate rises at the start of each period and falls at the first of three events: the on-time request expires, the maximum-duty limit is reached, or an over-current flag is seen outside the blanking window.

The over-current flag is level-sensitive. While it is high outside blanking, the gate stays low. Once it drops, the gate may resume within the same period's on-window. Every gate turn-on opens a blanking window of a fixed number of clocks, and the flag is ignored during that window. A global enable from the mode sequencer forces the gate low.

The gate output is a register. An on-time request of zero skips the pulse for that period.

Top module: `pwm_gate_ctl`

## Requirements
- R1: While reset is asserted the gate output is low; the first period starts at the first clock edge after reset is released.
- R2: A period lasts exactly L clock cycles, where L is the clamped period value sampled at the previous period boundary; rising gate edges of consecutive undisturbed pulses are L cycles apart.
- R3: The period value is clamped to MIN_LEN..MAX_LEN (defaults 250 and 1042 cycles, 200 kHz and 48 kHz at a 50 MHz clock).
- R4: Cycle index 0 of a period is its first cycle; the gate is high in cycle index p only if p is below the sampled on-time request; a request of 0 gives no pulse in that period.
- R5: The on-time never exceeds floor(L*31/32) cycles (96.9 %), whatever the request.
- R6: A high over-current flag sampled at an edge outside blanking makes the gate low after that edge; the gate stays low while the flag stays high and resumes one edge after the flag drops if the on-window is still open.
- R7: At the BLANK_CYC edges that follow each gate turn-on edge (default 18, 360 ns at 50 MHz), the over-current flag is ignored. A flag raised right after turn-on gives a pulse of BLANK_CYC+1 cycles.
- R8: A low enable sampled at a clock edge makes the gate low after that edge, whatever the cycle state.
- R9: Period and on-time inputs changed within a period take effect only at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_en_i | input | 1 | Global gate enable from the mode sequencer |
| period_i | input | CNT_W | Requested period length in clock cycles |
| duty_i | input | CNT_W | Requested on-time in clock cycles |
| ipk_i | input | 1 | Peak over-current flag, active high |
| gate_o | output | 1 | Registered gate drive |

## Verification
The on-time request is driven in several ways: below the duty ceiling, above it, at zero, and changed in the middle of a pulse. Together these separate the compare path, the maximum-duty ceiling, pulse skipping and sampling at the boundary. Period values below, inside and above the legal range show whether clamping works. The over-current flag is tested three ways: raised right after turn-on, which measures the blanking width; raised after blanking and then released, which shows the level behaviour and the resume; and as random bursts. The enable is dropped in mid-pulse and toggled at random. A cycle-accurate model in the bench follows all of it.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  // Force a requested period length into the legal window.
  function automatic int unsigned clamp_len(int unsigned raw, int unsigned lo, int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // Longest allowed on-time: floor(len * num / 2**shift).
  function automatic int unsigned max_on(int unsigned len, int unsigned num, int unsigned shift);
    return (len * num) >> shift;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned MIN_LEN    = 250,
  parameter int unsigned MAX_LEN    = 1042,
  parameter int unsigned MAXD_NUM   = 31,
  parameter int unsigned MAXD_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] duty_nxt,
  output logic [CNT_W-1:0] maxon_nxt,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] len_q,
  output logic [CNT_W-1:0] duty_q,
  output logic [CNT_W-1:0] maxon_q
);
  import pwm_gate_pkg::*;

  logic             boundary;
  logic [CNT_W-1:0] len_nxt;
  logic [CNT_W-1:0] len_in;

  assign boundary = (cnt_q == len_q - CNT_W'(1));
  assign len_in   = CNT_W'(clamp_len(int'(unsigned'(period_i)), MIN_LEN, MAX_LEN));

  always_comb begin
    if (boundary) begin
      cnt_nxt  = '0;
      len_nxt  = len_in;
      duty_nxt = duty_i;
    end else begin
      cnt_nxt  = cnt_q + CNT_W'(1);
      len_nxt  = len_q;
      duty_nxt = duty_q;
    end
  end

  assign maxon_nxt = CNT_W'(max_on(int'(unsigned'(len_nxt)), MAXD_NUM, MAXD_SHIFT));
  assign maxon_q   = CNT_W'(max_on(int'(unsigned'(len_q)), MAXD_NUM, MAXD_SHIFT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(MIN_LEN - 1);
      len_q  <= CNT_W'(MIN_LEN);
      duty_q <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
      len_q  <= len_nxt;
      duty_q <= duty_nxt;
    end
  end

endmodule

// File: rtl/pwm_blank.sv
module pwm_blank #(
  parameter int unsigned BLANK_CYC = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_d,
  input  logic gate_q,
  output logic blank_o
);
  localparam int unsigned BLK_W = $clog2(BLANK_CYC + 1);

  logic [BLK_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (gate_d && !gate_q) begin
      left_q <= BLK_W'(BLANK_CYC);
    end else if (!gate_d) begin
      left_q <= '0;
    end else if (left_q != '0) begin
      left_q <= left_q - BLK_W'(1);
    end
  end

  assign blank_o = (left_q != '0);

endmodule

// File: rtl/pwm_gate_ctl.sv
module pwm_gate_ctl #(
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned MIN_LEN    = 250,
  parameter int unsigned MAX_LEN    = 1042,
  parameter int unsigned MAXD_NUM   = 31,
  parameter int unsigned MAXD_SHIFT = 5,
  parameter int unsigned BLANK_CYC  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             ipk_i,
  output logic             gate_o
);

  logic [CNT_W-1:0] cnt_nxt, duty_nxt, maxon_nxt;
  logic [CNT_W-1:0] cnt_q, len_q, duty_q, maxon_q;
  logic             blank_w;
  logic             in_window;
  logic             trip_w;
  logic             gate_d;
  logic             gate_q;

  pwm_timebase #(
    .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
    .MAXD_NUM(MAXD_NUM), .MAXD_SHIFT(MAXD_SHIFT)
  ) u_tb (
    .clk(clk), .rst_n(rst_n),
    .period_i(period_i), .duty_i(duty_i),
    .cnt_nxt(cnt_nxt), .duty_nxt(duty_nxt), .maxon_nxt(maxon_nxt),
    .cnt_q(cnt_q), .len_q(len_q), .duty_q(duty_q), .maxon_q(maxon_q)
  );

  pwm_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n),
    .gate_d(gate_d), .gate_q(gate_q),
    .blank_o(blank_w)
  );

  // Gate wanted in the coming cycle: inside both the request and the ceiling.
  assign in_window = (cnt_nxt < duty_nxt) && (cnt_nxt < maxon_nxt);
  // Over-current seen outside the blanking window.
  assign trip_w    = ipk_i && !blank_w;
  assign gate_d    = gate_en_i && in_window && !trip_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/pwm_gate_ctl_chk.sv
module pwm_gate_ctl_chk #(
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned MIN_LEN = 250,
  parameter int unsigned MAX_LEN = 1042
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_en_i,
  input logic             ipk_i,
  input logic             gate_o,
  input logic             blank,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] len_q,
  input logic [CNT_W-1:0] duty_q,
  input logic [CNT_W-1:0] maxon_q
);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q); // R2

  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= CNT_W'(MIN_LEN)) && (len_q <= CNT_W'(MAX_LEN))); // R3

  AST_ZERO_DUTY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !gate_o); // R4

  AST_MAX_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> (cnt_q < maxon_q)); // R5

  AST_IPK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ipk_i && !blank) |=> !gate_o); // R6

  AST_BLANK_ON_TURNON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> blank); // R7

  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en_i |=> !gate_o); // R8

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> ($stable(duty_q) && $stable(len_q))); // R9

endmodule

bind pwm_gate_ctl pwm_gate_ctl_chk #(
  .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en_i(gate_en_i), .ipk_i(ipk_i),
  .gate_o(gate_o), .blank(blank_w), .cnt_q(cnt_q), .len_q(len_q),
  .duty_q(duty_q), .maxon_q(maxon_q)
);

// File: tb/pwm_gate_ctl_bench.sv
`timescale 1ns/1ps
module pwm_gate_ctl_bench;
  localparam int CNT_W = 11;
  localparam int LMIN  = 250;
  localparam int LMAX  = 1042;
  localparam int BLANK = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_en_i = 1'b0;
  logic [CNT_W-1:0] period_i = 11'd500;
  logic [CNT_W-1:0] duty_i = '0;
  logic ipk_i = 1'b0;
  logic gate_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_gate_ctl u_pwm_gate_ctl (
    .clk(clk), .rst_n(rst_n), .gate_en_i(gate_en_i),
    .period_i(period_i), .duty_i(duty_i), .ipk_i(ipk_i), .gate_o(gate_o)
  );

  function automatic int exp_len(int p);
    if (p < LMIN) return LMIN;
    if (p > LMAX) return LMAX;
    return p;
  endfunction

  function automatic int exp_win(int len, int d);
    int cap;
    cap = len - (len + 31) / 32;
    return (d < cap) ? d : cap;
  endfunction

  task automatic check(bit ok, string req, int act, int expv, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Reference model, advanced at every rising edge from the requirements.
  int    m_ph, m_len, m_win, m_age;
  bit    m_gate, m_valid;
  string m_tag = "R4";
  always @(posedge clk) begin
    bit blanked, want, nxt;
    if (!rst_n) begin
      m_ph = LMIN - 1; m_len = LMIN; m_win = 0; m_gate = 0; m_age = 0; m_valid = 0;
    end else begin
      if (m_ph == m_len - 1) begin
        m_ph  = 0;
        m_len = exp_len(int'(period_i));
        m_win = exp_win(m_len, int'(duty_i));
      end else m_ph++;
      blanked = m_gate && (m_age < BLANK);
      want    = m_ph < m_win;
      nxt     = gate_en_i && want && !(ipk_i && !blanked);
      if (!gate_en_i) m_tag = "R8";
      else if (want && ipk_i) m_tag = blanked ? "R7" : "R6";
      else if (m_win == 0) m_tag = "R4";
      else if (m_win < int'(duty_i)) m_tag = "R5";
      else m_tag = "R2";
      if (nxt && m_gate) m_age++; else m_age = 0;
      m_gate  = nxt;
      m_valid = 1;
    end
  end

  // Per-cycle comparison and pulse spacing monitor.
  int cyc = 0, last_rise = -1, last_period = 0, nrise = 0;
  bit prev_g = 0;
  always @(negedge clk) begin
    cyc++;
    if (m_valid && rst_n) check(gate_o == m_gate, m_tag, gate_o, m_gate, "model cycle");
    if (gate_o && !prev_g) begin
      if (last_rise >= 0) last_period = cyc - last_rise;
      last_rise = cyc;
      nrise++;
    end
    prev_g = gate_o;
  end

  task automatic wait_rise();
    bit p;
    p = gate_o;
    forever begin
      @(negedge clk);
      if (gate_o && !p) break;
      p = gate_o;
    end
  endtask

  task automatic width_to_fall(output int w);
    w = 1;
    forever begin
      @(negedge clk);
      if (gate_o) w++; else break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w, n0, highs;
    void'($urandom(32'd20240611));
    // R1: reset holds the gate low
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      gate_en_i = 1'b1; duty_i = 11'd100;
      check(gate_o == 1'b0, "R1", gate_o, 0, "gate during reset");
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(gate_o == 1'b1, "R1", gate_o, 1, "first period starts at first edge");

    repeat (1600) @(negedge clk);
    check(last_period == 500, "R2", last_period, 500, "pulse spacing");
    wait_rise(); width_to_fall(w);
    check(w == 100, "R4", w, 100, "on-time");

    duty_i = 11'd1000;
    repeat (1200) @(negedge clk);
    wait_rise(); width_to_fall(w);
    check(w == 484, "R5", w, 484, "ceiling at L=500");

    duty_i = 11'd100; period_i = 11'd10;
    repeat (1200) @(negedge clk);
    check(last_period == 250, "R3", last_period, 250, "low clamp");
    period_i = 11'd2000;
    repeat (3500) @(negedge clk);
    check(last_period == 1042, "R3", last_period, 1042, "high clamp");
    duty_i = 11'd2000;
    repeat (2200) @(negedge clk);
    wait_rise(); width_to_fall(w);
    check(w == 1009, "R5", w, 1009, "ceiling at L=1042");

    // R9: change mid-pulse takes effect next period
    period_i = 11'd500; duty_i = 11'd100;
    repeat (2200) @(negedge clk);
    wait_rise();
    repeat (20) @(negedge clk);
    duty_i = 11'd300;
    w = 21;
    forever begin @(negedge clk); if (gate_o) w++; else break; end
    check(w == 100, "R9", w, 100, "old request kept");
    wait_rise(); width_to_fall(w);
    check(w == 300, "R9", w, 300, "new request at boundary");

    // R4: zero request skips pulses
    duty_i = '0;
    repeat (1100) @(negedge clk);
    n0 = nrise;
    repeat (1500) @(negedge clk);
    check(nrise == n0, "R4", nrise - n0, 0, "pulses with zero request");

    // R7: flag right after turn-on
    duty_i = 11'd200;
    wait_rise();
    ipk_i = 1'b1;
    width_to_fall(w);
    check(w == BLANK + 1, "R7", w, BLANK + 1, "blanked pulse width");
    repeat (10) @(negedge clk);
    check(gate_o == 1'b0, "R6", gate_o, 0, "held off while flag high");
    ipk_i = 1'b0;
    @(negedge clk);
    check(gate_o == 1'b1, "R6", gate_o, 1, "resume after flag drops");
    repeat (400) @(negedge clk);

    // R6: flag after blanking
    wait_rise();
    repeat (50) @(negedge clk);
    ipk_i = 1'b1;
    @(negedge clk);
    check(gate_o == 1'b0, "R6", gate_o, 0, "trip outside blanking");
    ipk_i = 1'b0;
    repeat (400) @(negedge clk);

    // R8: enable drop mid-pulse
    wait_rise();
    repeat (30) @(negedge clk);
    gate_en_i = 1'b0;
    @(negedge clk);
    check(gate_o == 1'b0, "R8", gate_o, 0, "enable low forces gate off");
    highs = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (gate_o) highs++; end
    check(highs == 0, "R8", highs, 0, "cycles high while disabled");
    gate_en_i = 1'b1;

    // Random mix, followed by the reference model every cycle.
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 299) == 0) duty_i = CNT_W'($urandom_range(0, 1100));
      if ($urandom_range(0, 499) == 0) period_i = CNT_W'($urandom_range(0, 2047));
      if (ipk_i) ipk_i = ($urandom_range(0, 3) != 0);
      else       ipk_i = ($urandom_range(0, 149) == 0);
      if ($urandom_range(0, 1999) == 0) gate_en_i = !gate_en_i;
      if (!gate_en_i && $urandom_range(0, 199) == 0) gate_en_i = 1'b1;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule